// File: doc/BRIEF.md
# Ten-Bit ECC Symbol Packer

This block converts between eight 10-bit error-correction symbols and the ten-byte form in which they sit in a flash page's spare area. In pack mode it accepts four 32-bit words, each carrying two symbols, and returns the ten storage bytes one at a time. In unpack mode it accepts the ten stored bytes and returns the eight symbols in the order a syndrome engine expects to be loaded: the highest symbol first.

Seen as a bit stream, both directions are one layout. The eight symbols are concatenated, symbol 0 in the lowest bits, into an 80-bit value that is split into bytes least significant first. When an unpack transfer brings in ten bytes that are all 0xFF, the page is taken to be erased. No symbols are sent, and a flag tells the caller to skip correction.

Both sides are valid/ready streams. A mode input picks the direction for each transfer.

Top module: `ecc_symbol_packer`

## Requirements
- R1: In pack mode the ten bytes leave byte 0 first. Symbol k occupies bits 10k+9..10k of an 80-bit stream, and byte b is bits 8b+7..8b of it. So, per pair of words p0,p1: byte0=p0[7:0], byte1={p0[21:16],p0[9:8]}, byte2={p1[3:0],p0[25:22]}, byte3={p1[17:16],p1[9:4]}, byte4=p1[25:18].
- R2: Input word w (the w-th accepted, from 0) supplies symbol 2w from bits 9:0 and symbol 2w+1 from bits 25:16. Bits 15:10 and 31:26 have no effect on the output.
- R3: In unpack mode the first received byte is byte 0, taken from in_data[7:0]. The symbols of the same 80-bit stream leave on out_data[9:0] in the order symbol 7, 6, ..., 0.
- R4: An unpack transfer whose ten bytes are all 0xFF emits no symbols. It raises erased, drops busy and leaves the block ready for the next transfer.
- R5: erased is low after reset. It clears when the first item of the next transfer is accepted, and it stays low if any of the ten bytes differs from 0xFF.
- R6: mode_unpack (0 = pack, 1 = unpack) is sampled only with the first item of a transfer. Changes during the transfer have no effect.
- R7: busy rises with the first accepted item and falls when the last output is accepted. in_ready is low while outputs are pending.
- R8: While out_valid is high and out_ready low, out_valid stays high and out_data stays unchanged.
- R9: After reset, out_valid, busy and erased are low and in_ready is high.
- R10: In pack mode out_data[9:8] are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_unpack | input | 1 | 0 pack, 1 unpack; sampled with the first item |
| in_valid | input | 1 | Input item valid |
| in_ready | output | 1 | Block accepts an input item |
| in_data | input | 32 | Word (pack) or byte in bits 7:0 (unpack) |
| out_valid | output | 1 | Output item valid |
| out_ready | input | 1 | Consumer accepts the output item |
| out_data | output | 10 | Byte in bits 7:0 (pack) or symbol (unpack) |
| busy | output | 1 | A transfer is in progress |
| erased | output | 1 | The last unpack transfer saw an erased page |

## Verification
The hardest cases to reach are the ones where erased detection nearly fires. One is a transfer of nine 0xFF bytes followed by a single cleared bit in the last byte. The other is a valid transfer that comes right after an erased one. Both leave state from the previous transfer in the buffer. The bench sends exactly these sequences and checks the flag and the full symbol output. It also flips the mode line right after the first word of a pack transfer, and it stalls the consumer for a different number of cycles on each output.

// File: rtl/ecc_pk_pkg.sv
package ecc_pk_pkg;
    parameter int SYM_W   = 10;
    parameter int N_SYM   = 8;
    parameter int BYTE_W  = 8;
    parameter int WORD_W  = 32;
    parameter int HI_LSB  = 16;

    localparam int BUF_W  = SYM_W * N_SYM;
    localparam int N_BYTE = BUF_W / BYTE_W;
    localparam int N_WORD = N_SYM / 2;
    localparam int CNT_W  = $clog2(N_BYTE + 1);

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_EMIT = 1'b1
    } state_e;

    typedef struct packed {
        state_e             state;
        logic [CNT_W-1:0]   in_cnt;
        logic [CNT_W-1:0]   out_cnt;
        logic               unpack;
        logic               busy;
        logic               erased;
        logic [BUF_W-1:0]   bits;
    } ctl_s;
endpackage

// File: rtl/ecc_buf_insert.sv
module ecc_buf_insert
    import ecc_pk_pkg::*;
(
    input  logic [BUF_W-1:0]  buf_i,
    input  logic [CNT_W-1:0]  idx,
    input  logic [WORD_W-1:0] data,
    input  logic              unpack,
    output logic [BUF_W-1:0]  buf_o
);
    always_comb begin
        buf_o = buf_i;
        if (unpack) begin
            for (int b = 0; b < N_BYTE; b++) begin
                if (idx == CNT_W'(b)) begin
                    buf_o[b*BYTE_W +: BYTE_W] = data[BYTE_W-1:0];
                end
            end
        end else begin
            for (int w = 0; w < N_WORD; w++) begin
                if (idx == CNT_W'(w)) begin
                    buf_o[(2*w)*SYM_W +: SYM_W]   = data[SYM_W-1:0];
                    buf_o[(2*w+1)*SYM_W +: SYM_W] = data[HI_LSB +: SYM_W];
                end
            end
        end
    end
endmodule

// File: rtl/ecc_item_select.sv
module ecc_item_select
    import ecc_pk_pkg::*;
(
    input  logic [BUF_W-1:0] buf_i,
    input  logic [CNT_W-1:0] idx,
    input  logic             unpack,
    output logic [SYM_W-1:0] item
);
    logic [SYM_W-1:0]  sym_a  [N_SYM];
    logic [BYTE_W-1:0] byte_a [N_BYTE];

    for (genvar k = 0; k < N_SYM; k++) begin : g_sym
        assign sym_a[k] = buf_i[k*SYM_W +: SYM_W];
    end
    for (genvar b = 0; b < N_BYTE; b++) begin : g_byte
        assign byte_a[b] = buf_i[b*BYTE_W +: BYTE_W];
    end

    always_comb begin
        item = '0;
        if (unpack) begin
            for (int k = 0; k < N_SYM; k++) begin
                if (idx == CNT_W'(N_SYM - 1 - k)) item = sym_a[k];
            end
        end else begin
            for (int b = 0; b < N_BYTE; b++) begin
                if (idx == CNT_W'(b)) item = SYM_W'(byte_a[b]);
            end
        end
    end
endmodule

// File: rtl/ecc_erase_detect.sv
module ecc_erase_detect
    import ecc_pk_pkg::*;
(
    input  logic [BUF_W-1:0] buf_i,
    output logic             all_ones
);
    logic [N_BYTE-1:0] byte_ff;
    for (genvar b = 0; b < N_BYTE; b++) begin : g_ff
        assign byte_ff[b] = &buf_i[b*BYTE_W +: BYTE_W];
    end
    assign all_ones = &byte_ff;
endmodule

// File: rtl/ecc_symbol_packer.sv
module ecc_symbol_packer
    import ecc_pk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_unpack,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [SYM_W-1:0]  out_data,
    output logic              busy,
    output logic              erased
);
    ctl_s q, d;

    logic             unpack_now;
    logic             acc_in;
    logic             last_in;
    logic             last_out;
    logic [BUF_W-1:0] ins_buf;
    logic             ins_ones;

    assign in_ready   = (q.state == ST_FILL);
    assign out_valid  = (q.state == ST_EMIT);
    assign busy       = q.busy;
    assign erased     = q.erased;
    assign acc_in     = in_valid && in_ready;
    assign unpack_now = q.busy ? q.unpack : mode_unpack;
    assign last_in    = q.in_cnt == (unpack_now ? CNT_W'(N_BYTE - 1) : CNT_W'(N_WORD - 1));
    assign last_out   = q.out_cnt == (q.unpack ? CNT_W'(N_SYM - 1) : CNT_W'(N_BYTE - 1));

    ecc_buf_insert u_insert (
        .buf_i  (q.bits),
        .idx    (q.in_cnt),
        .data   (in_data),
        .unpack (unpack_now),
        .buf_o  (ins_buf)
    );

    ecc_erase_detect u_erase (
        .buf_i    (ins_buf),
        .all_ones (ins_ones)
    );

    ecc_item_select u_select (
        .buf_i  (q.bits),
        .idx    (q.out_cnt),
        .unpack (q.unpack),
        .item   (out_data)
    );

    always_comb begin
        d = q;
        if (q.state == ST_FILL) begin
            if (acc_in) begin
                d.bits   = ins_buf;
                d.in_cnt = q.in_cnt + 1'b1;
                if (!q.busy) begin
                    d.busy   = 1'b1;
                    d.unpack = mode_unpack;
                    d.erased = 1'b0;
                end
                if (last_in) begin
                    d.in_cnt = '0;
                    if (unpack_now && ins_ones) begin
                        d.erased = 1'b1;
                        d.busy   = 1'b0;
                    end else begin
                        d.state   = ST_EMIT;
                        d.out_cnt = '0;
                    end
                end
            end
        end else begin
            if (out_ready) begin
                d.out_cnt = q.out_cnt + 1'b1;
                if (last_out) begin
                    d.out_cnt = '0;
                    d.state   = ST_FILL;
                    d.busy    = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state   <= ST_FILL;
            q.in_cnt  <= '0;
            q.out_cnt <= '0;
            q.unpack  <= 1'b0;
            q.busy    <= 1'b0;
            q.erased  <= 1'b0;
            q.bits    <= '0;
        end else begin
            q <= d;
        end
    end

    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    p_no_input_in_emit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready && busy);

    p_pack_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !q.unpack |-> out_data[SYM_W-1:BYTE_W] == '0);

    p_erased_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        erased |-> !out_valid);

    p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(q.unpack));

    p_busy_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> in_ready);
endmodule

// File: tb/test_ecc_symbol_packer.sv
`timescale 1ns/1ps
module test_ecc_symbol_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_unpack = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [9:0]  out_data;
    logic        busy;
    logic        erased;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ecc_symbol_packer i_ecc_symbol_packer (
        .clk(clk), .rst_n(rst_n), .mode_unpack(mode_unpack),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .busy(busy), .erased(erased)
    );

    localparam logic [79:0] VEC [4] = '{
        80'h0123_4567_89AB_CDEF_0123,
        80'h0000_0000_0000_0000_0000,
        80'hA5A5_5A5A_F0F0_0F0F_1234,
        80'h8000_0000_0000_0000_0001
    };
    localparam logic [31:0] JUNK [4] = '{
        32'hFC00_FC00, 32'hA800_5400, 32'h5400_A800, 32'h0400_8000
    };

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic get(input int stall, output logic [9:0] d);
        @(negedge clk);
        while (!out_valid) @(negedge clk);
        d = out_data;
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk(out_valid && out_data == d, "R8 hold", 32'(out_data), 32'(d));
        end
        out_ready = 1'b1;
        @(posedge clk);
        #1 out_ready = 1'b0;
    endtask

    function automatic logic [7:0] exp_byte(input logic [31:0] p0, input logic [31:0] p1, input int k);
        case (k)
            0:       return p0[7:0];
            1:       return {p0[21:16], p0[9:8]};
            2:       return {p1[3:0], p0[25:22]};
            3:       return {p1[17:16], p1[9:4]};
            default: return p1[25:18];
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] w [4];
        logic [7:0]  bytes [10];
        logic [9:0]  got;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(!out_valid && in_ready && !busy && !erased, "R9 reset",
            {28'd0, out_valid, in_ready, busy, erased}, 32'h4);

        // Table walk: pack then unpack each vector
        for (int v = 0; v < 4; v++) begin
            for (int i = 0; i < 4; i++) begin
                w[i] = (JUNK[v] & 32'hFC00_FC00) |
                       {6'd0, VEC[v][(2*i+1)*10 +: 10], 6'd0, VEC[v][(2*i)*10 +: 10]};
            end
            mode_unpack = 1'b0;
            chk(!busy, "R7 idle before", 32'(busy), 0);
            for (int i = 0; i < 4; i++) begin
                put(w[i]);
                if (i == 0) begin
                    @(negedge clk);
                    chk(busy, "R7 busy after first", 32'(busy), 1);
                end
            end
            for (int b = 0; b < 10; b++) begin
                get((b + v) % 3, got);
                bytes[b] = exp_byte(w[2*(b/5)], w[2*(b/5)+1], b % 5);
                chk(got == {2'b00, bytes[b]}, "R1 R2 R10 pack byte", 32'(got), 32'(bytes[b]));
            end
            @(negedge clk);
            chk(!busy && in_ready, "R7 idle after", {30'd0, busy, in_ready}, 1);
            mode_unpack = 1'b1;
            for (int b = 0; b < 10; b++) put({24'hFFFFFF, bytes[b]});
            for (int k = 7; k >= 0; k--) begin
                get(k % 2, got);
                chk(got == VEC[v][k*10 +: 10], "R3 unpack symbol", 32'(got), 32'(VEC[v][k*10 +: 10]));
            end
        end

        // R4 erased page
        mode_unpack = 1'b1;
        for (int b = 0; b < 10; b++) put(32'h0000_00FF);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(!out_valid && erased && !busy && in_ready, "R4 erased",
                {28'd0, out_valid, erased, busy, in_ready}, 32'h5);
        end

        // R5 near-erased right after erased: last byte 0xFE
        for (int b = 0; b < 10; b++) begin
            put(b == 9 ? 32'h0000_00FE : 32'h0000_00FF);
            if (b == 0) begin
                @(negedge clk);
                chk(!erased, "R5 clear on start", 32'(erased), 0);
            end
        end
        for (int k = 7; k >= 0; k--) begin
            get(0, got);
            chk(got == (k == 7 ? 10'h3FB : 10'h3FF), "R5 near-erased symbol", 32'(got),
                32'(k == 7 ? 10'h3FB : 10'h3FF));
        end
        @(negedge clk);
        chk(!erased, "R5 stays low", 32'(erased), 0);

        // R6 mode change mid-transfer ignored
        mode_unpack = 1'b0;
        for (int i = 0; i < 4; i++) w[i] = {6'd0, 10'(i*37+5), 6'd0, 10'(i*91+3)};
        put(w[0]);
        mode_unpack = 1'b1;
        for (int i = 1; i < 4; i++) put(w[i]);
        @(negedge clk);
        chk(out_valid, "R6 pack length kept", 32'(out_valid), 1);
        for (int b = 0; b < 10; b++) begin
            get(0, got);
            chk(got == {2'b00, exp_byte(w[2*(b/5)], w[2*(b/5)+1], b % 5)}, "R6 pack byte",
                32'(got), 32'(exp_byte(w[2*(b/5)], w[2*(b/5)+1], b % 5)));
        end
        @(negedge clk);
        chk(!busy && !out_valid, "R7 done", {30'd0, busy, out_valid}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule